// File: doc/BRIEF.md
# Holdover Frequency History Accumulator

This block keeps two running averages of a loop's frequency offset. Holdover logic uses them when the reference is lost. Each average is a first-order recursive low-pass filter of the form `acc += (x - acc) >>> k`. Each accumulator carries fraction bits equal to its largest shift, so truncation does not drift the average. The long-term filter has six corner settings and the short-term filter has four. Each step up in the setting adds one to the shift, which halves the bandwidth.

Samples count only while the loop reports lock. The long-term history is built by a small state machine. After reset or a flush it sits in **EMPTY**. The first accepted sample moves it to **EXPRESS** (transition *start*). In EXPRESS the shift is four less than the programmed one, so the history fills quickly. Once 2^k samples have been accepted, where k is the programmed long-term shift, the machine moves to **BUILT** (transition *filled*). It then raises the ready flag and applies the programmed shift. A flush moves any state back to EMPTY (transition *flush*) and clears the long-term accumulator. The short-term filter has no such build phase.

Top module: `holdover_hist`

## Requirements
- R1: After reset both history outputs read 0 and `lt_ready` is low.
- R2: In BUILT, each accepted sample updates the long-term accumulator with shift k = LT_BASE + sel. Here sel is `lt_corner`, and the codes 6 and 7 act as 5.
- R3: In EMPTY and EXPRESS, each accepted sample uses shift k - EXP_DROP. EXP_DROP is 4 by default.
- R4: `lt_ready` rises in the cycle after the accepted sample that brings the fill count to at least 2^k. It stays high until a flush.
- R5: A flush clears the long-term accumulator, the fill count and `lt_ready`. A sample offered in the same cycle is dropped from the long-term filter but still updates the short-term filter.
- R6: Each accepted sample updates the short-term accumulator with shift ST_BASE + `st_corner`.
- R7: A sample with `smp_valid` low or `loop_locked` low changes neither history and does not advance the fill count.
- R8: Each history output is the floor of its accumulator (the fraction bits dropped). It changes in the cycle after the sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Offset sample strobe |
| smp_offset | input | DATA_W | Signed frequency offset sample |
| loop_locked | input | 1 | Loop lock indication; samples are accepted only while high |
| flush_lt | input | 1 | Discard and rebuild the long-term history |
| lt_corner | input | 3 | Long-term corner select (0 widest, 5 narrowest) |
| st_corner | input | 2 | Short-term corner select (0 widest, 3 narrowest) |
| lt_history | output | DATA_W | Long-term average, integer part |
| st_history | output | DATA_W | Short-term average, integer part |
| lt_ready | output | 1 | Long-term history built |

## Verification
Both history outputs and `lt_ready` are registered directly from the edge that takes a sample. Each result is therefore due exactly one rising edge after the stimulus is applied. The driver applies each stimulus on a falling edge and tags the expected values with the next cycle number. The monitor compares them on the falling edge of that cycle. This keeps every comparison half a period away from the edge that changes the outputs.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic [1:0] {
        HS_EMPTY   = 2'd0,
        HS_EXPRESS = 2'd1,
        HS_BUILT   = 2'd2
    } hist_state_e;
endpackage

// File: rtl/hist_iir.sv
module hist_iir #(
    parameter int DATA_W = 16,
    parameter int FRAC   = 11,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] x,
    input  logic [SH_W-1:0]   shift,
    output logic [DATA_W-1:0] hist
);
    localparam int ACC_W = DATA_W + FRAC;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W:0]   x_ext;
    logic signed [ACC_W:0]   acc_ext;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;

    always_comb begin
        x_ext   = {x[DATA_W-1], x, {FRAC{1'b0}}};
        acc_ext = {acc[ACC_W-1], acc};
        diff    = x_ext - acc_ext;
        step    = diff >>> shift;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + step[ACC_W-1:0];
        end
    end

    assign hist = acc[ACC_W-1:FRAC];

    // R7: without a sample or clear the accumulator holds
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(acc));

    // R5: a clear empties the accumulator
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int LT_BASE  = 6,
    parameter int EXP_DROP = 4,
    parameter int SH_W     = 4,
    parameter int CNT_W    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            take,
    input  logic [2:0]      corner,
    output logic [SH_W-1:0] shift,
    output logic            clr,
    output logic            ready
);
    localparam logic [2:0] SEL_MAX = 3'd5;

    hist_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [2:0]       sel;
    logic [SH_W-1:0]  k_tgt;
    logic [CNT_W-1:0] target;

    always_comb begin
        sel    = (corner > SEL_MAX) ? SEL_MAX : corner;
        k_tgt  = SH_W'(LT_BASE) + SH_W'(sel);
        target = CNT_W'(1) << k_tgt;
    end

    // next state and fill count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (flush) begin
            state_d = HS_EMPTY;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                HS_EMPTY: if (take) begin
                    cnt_d   = CNT_W'(1);
                    state_d = HS_EXPRESS;
                end
                HS_EXPRESS: if (take) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
                HS_BUILT: ;
                default: state_d = HS_EMPTY;
            endcase
            if (state_d == HS_EXPRESS && cnt_d >= target) begin
                state_d = HS_BUILT;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        clr = flush;
        unique case (state_q)
            HS_BUILT: begin
                shift = k_tgt;
                ready = 1'b1;
            end
            default: begin
                shift = k_tgt - SH_W'(EXP_DROP);
                ready = 1'b0;
            end
        endcase
    end

    // R4: ready only rises on an accepted sample without flush
    a_r4_ready_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(take && !flush));

    // R5: flush always returns the history to empty
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == HS_EMPTY && !ready && cnt_q == '0));
endmodule

// File: rtl/holdover_hist.sv
module holdover_hist #(
    parameter int DATA_W   = 16,
    parameter int LT_BASE  = 6,
    parameter int ST_BASE  = 4,
    parameter int EXP_DROP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_offset,
    input  logic              loop_locked,
    input  logic              flush_lt,
    input  logic [2:0]        lt_corner,
    input  logic [1:0]        st_corner,
    output logic [DATA_W-1:0] lt_history,
    output logic [DATA_W-1:0] st_history,
    output logic              lt_ready
);
    localparam int LT_KMAX = LT_BASE + 5;
    localparam int ST_KMAX = ST_BASE + 3;
    localparam int K_MAX   = (LT_KMAX > ST_KMAX) ? LT_KMAX : ST_KMAX;
    localparam int SH_W    = $clog2(K_MAX + 1);
    localparam int CNT_W   = LT_KMAX + 1;

    logic            take;
    logic            lt_clr;
    logic [SH_W-1:0] lt_shift;
    logic [SH_W-1:0] st_shift;

    assign take     = smp_valid & loop_locked;
    assign st_shift = SH_W'(ST_BASE) + SH_W'(st_corner);

    hist_ctrl #(
        .LT_BASE (LT_BASE),
        .EXP_DROP(EXP_DROP),
        .SH_W    (SH_W),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_lt),
        .take  (take),
        .corner(lt_corner),
        .shift (lt_shift),
        .clr   (lt_clr),
        .ready (lt_ready)
    );

    hist_iir #(.DATA_W(DATA_W), .FRAC(LT_KMAX), .SH_W(SH_W)) u_long (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lt_clr),
        .en   (take),
        .x    (smp_offset),
        .shift(lt_shift),
        .hist (lt_history)
    );

    hist_iir #(.DATA_W(DATA_W), .FRAC(ST_KMAX), .SH_W(SH_W)) u_short (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (1'b0),
        .en   (take),
        .x    (smp_offset),
        .shift(st_shift),
        .hist (st_history)
    );

    // R4: once built, ready holds until a flush
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lt_ready && !flush_lt) |=> lt_ready);

    // R7: rejected samples leave both histories untouched
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !flush_lt) |=> ($stable(lt_history) && $stable(st_history)));
endmodule

// File: tb/test_holdover_hist.sv
module test_holdover_hist;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int LT_BASE    = 6;
    localparam int ST_BASE    = 4;
    localparam int EXP_DROP   = 4;
    localparam int LT_FRAC    = LT_BASE + 5;
    localparam int ST_FRAC    = ST_BASE + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_offset = '0;
    logic              loop_locked = 1'b0;
    logic              flush_lt = 1'b0;
    logic [2:0]        lt_corner = '0;
    logic [1:0]        st_corner = '0;
    logic [DATA_W-1:0] lt_history;
    logic [DATA_W-1:0] st_history;
    logic              lt_ready;

    holdover_hist #(
        .DATA_W(DATA_W), .LT_BASE(LT_BASE), .ST_BASE(ST_BASE), .EXP_DROP(EXP_DROP)
    ) i_holdover_hist (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_offset(smp_offset),
        .loop_locked(loop_locked), .flush_lt(flush_lt), .lt_corner(lt_corner),
        .st_corner(st_corner), .lt_history(lt_history), .st_history(st_history),
        .lt_ready(lt_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    due;
        int    lt;
        int    st;
        bit    rdy;
        string why;
    } exp_t;

    exp_t   sb_q[$];
    int     cyc = 0;
    int     checks = 0;
    int     failures = 0;
    bit     done = 1'b0;

    longint m_lt = 0;
    longint m_st = 0;
    int     m_cnt = 0;
    bit     m_built = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint iir(longint acc, int x, int frac, int k);
        return acc + (((longint'(x) <<< frac) - acc) >>> k);
    endfunction

    // driver: apply one cycle of stimulus and queue the expected outputs
    task automatic drive(input int x, input bit v, input bit lk, input bit fl,
                         input int ls, input int ss, input string why);
        int   klt;
        int   kuse;
        exp_t e;
        @(negedge clk);
        smp_offset  = DATA_W'(x);
        smp_valid   = v;
        loop_locked = lk;
        flush_lt    = fl;
        lt_corner   = 3'(ls);
        st_corner   = 2'(ss);
        klt = LT_BASE + ((ls > 5) ? 5 : ls);
        if (fl) begin
            m_lt = 0; m_cnt = 0; m_built = 1'b0;
        end else if (v && lk) begin
            kuse = m_built ? klt : klt - EXP_DROP;
            m_lt = iir(m_lt, x, LT_FRAC, kuse);
            if (!m_built) begin
                m_cnt++;
                if (m_cnt >= (1 << klt)) m_built = 1'b1;
            end
        end
        if (v && lk) m_st = iir(m_st, x, ST_FRAC, ST_BASE + ss);
        e.due = cyc + 1;
        e.lt  = int'(m_lt >>> LT_FRAC);
        e.st  = int'(m_st >>> ST_FRAC);
        e.rdy = m_built;
        e.why = why;
        sb_q.push_back(e);
    endtask

    // monitor: compare results half a period after the edge that made them
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            checks += 3;
            if (int'($signed(lt_history)) != e.lt) begin
                failures++;
                $display("FAIL %s R2 lt_history actual=%0d expected=%0d", e.why,
                         $signed(lt_history), e.lt);
            end
            if (int'($signed(st_history)) != e.st) begin
                failures++;
                $display("FAIL %s R6 st_history actual=%0d expected=%0d", e.why,
                         $signed(st_history), e.st);
            end
            if (lt_ready != e.rdy) begin
                failures++;
                $display("FAIL %s R4 lt_ready actual=%0b expected=%0b", e.why,
                         lt_ready, e.rdy);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (lt_history != '0 || st_history != '0 || lt_ready) begin
            failures++;
            $display("FAIL R1 reset actual=%0d/%0d/%0b expected=0/0/0",
                     lt_history, st_history, lt_ready);
        end
        drive(0, 1'b0, 1'b0, 1'b0, 0, 0, "R1 idle");

        // R3 R8: express fill at corner 0 (64 samples), ready at the last one
        for (int i = 0; i < 70; i++)
            drive(800 + ((i * 37) % 200) - 100, 1'b1, 1'b1, 1'b0, 0, 0, "R3 express");

        // R2: built filter, step to negative offsets, other corners
        for (int i = 0; i < 40; i++)
            drive(-1200 + i * 11, 1'b1, 1'b1, 1'b0, 2, 1, "R2 built");

        // R7: unlocked and invalid samples are ignored
        for (int i = 0; i < 10; i++)
            drive(30000, 1'b1, 1'b0, 1'b0, 2, 1, "R7 unlocked");
        for (int i = 0; i < 5; i++)
            drive(-30000, 1'b0, 1'b1, 1'b0, 2, 1, "R7 invalid");

        // R2: corner code 7 acts as 5
        for (int i = 0; i < 20; i++)
            drive(20000, 1'b1, 1'b1, 1'b0, 7, 3, "R2 clamp");

        // R5: flush with a coincident sample
        drive(5000, 1'b1, 1'b1, 1'b1, 1, 2, "R5 flush");
        for (int i = 0; i < 132; i++)
            drive(-3000 + (i % 5) * 400, 1'b1, 1'b1, 1'b0, 1, 2, "R3 refill");

        // R5 R3: flush, slowest corner, long express then built
        drive(0, 1'b0, 1'b1, 1'b1, 5, 0, "R5 flush idle");
        for (int i = 0; i < 2060; i++)
            drive((i < 1000) ? 12000 : -7000, 1'b1, 1'b1, 1'b0, 5, 0, "R4 slow fill");

        drive(0, 1'b0, 1'b0, 1'b0, 5, 0, "R8 drain");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule